// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer Channel

This block is a single 16-bit down-counting timer channel. It counts either on system clocks divided by a selectable prescaler (4, 16 or 256) or on edges of an external gate pin. A 6-bit configuration word selects how it runs. It can fire once, reload forever, act as a retriggerable watchdog, or split the count into an 8-bit period and an 8-bit duty to form a PWM waveform.

The channel drives two outputs. The first is a pulse/toggle output whose resting level is set by a polarity bit. The second is a four-cycle strobe, raised on every underflow, meant for an interrupt controller. The live count and a running flag are also brought out. A host writes the configuration word with `cfg_we` and writes a full 16-bit value with `load_we`. Splitting this traffic into bus bytes is left to the logic around the block.

Top module: `tmr_channel`

## Requirements
- R1: After a synchronous active-low reset, `count_out` is 0xFFFF, and `running`, `pulse_out` and `strobe_out` are all 0. The stored reload value is also 0xFFFF.
- R2: The divide ratio comes from `cfg_word[1:0]`. The value 1x divides by 4, 01 by 16 and 00 by 256. When a one-shot is started with value N and no gate effect, the underflow lands exactly divide × (N+1) clocks after the `load_we` edge. The count then parks at 0xFFFF and `running` drops.
- R3: `pulse_out` equals an internal toggle flag XOR `cfg_word[4]`. Starting a count sets the flag. A configuration write that changes bit 4 changes `pulse_out` on the next cycle.
- R4: Every underflow inverts the toggle flag and holds `strobe_out` high for exactly 4 clocks.
- R5: The mode field is `cfg_word[3:2]`: 00 one-shot, 01 continuous, 10 watchdog, 11 PWM. In modes 01 and 11 an underflow reloads the stored value and counting goes on, so a continuous period is divide × (N+1) clocks.
- R6: In watchdog mode, `load_we` ignores `load_val` and restarts the count from the stored value, even while the count is running. On expiry the count parks at 0xFFFF and stops.
- R7: In PWM mode, with stored value {H,L} and H < L, `pulse_out` holds its active level for divide × (H+1) clocks after a start or reload. It then returns to the polarity level until the underflow, which comes divide × (L+1) clocks after the reload.
- R8: In PWM mode while running, `load_we` only replaces the stored value. The live count and the prescaler phase continue, and the new value is applied at the next reload.
- R9: With `cfg_word[1:0]` = 11 and `cfg_word[5]` = 0, the gate level, seen after a 2-flop synchronizer, enables counting. While the gate is low, both the count and the prescaler phase hold. Counting resumes from the held state when the gate goes high again.
- R10: With `cfg_word[5]` = 1, the count decrements once per synchronized gate edge. The edge is falling when `cfg_word[0]` = 1 and rising when it is 0, and the other edge is ignored. A start value of N underflows on edge N+1.
- R11: In edge-clocked PWM mode, an edge that finds the low byte at zero causes an underflow. Any other edge decrements both bytes. If the high byte wraps from 0 to 0xFF, the toggle flag is cleared.
- R12: A configuration write stops the count and holds its value, and `running` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 6 | [5] edge clock, [4] polarity, [3:2] mode, [1:0] divide/gate |
| load_we | input | 1 | Start / retrigger / reload-value write strobe |
| load_val | input | 16 | Start or reload value |
| gate_in | input | 1 | External gate (asynchronous) |
| pulse_out | output | 1 | Toggle flag XOR polarity |
| strobe_out | output | 1 | Four-clock underflow strobe |
| count_out | output | 16 | Live count |
| running | output | 1 | Count is active |

## Verification
The hardest state to reach from the ports is a gate-enabled count paused partway through a prescaler period, with the held phase then resumed. The stimulus raises the gate for a known number of clocks, drops it, and confirms that the count stays frozen. It then raises the gate again and checks that the remaining time equals the full period minus the enabled clocks, plus the synchronizer delay. The PWM write during a running period is timed to land just after a reload, which proves that neither the live count nor the prescaler phase moved. Edge-clocked PWM is walked through the high-byte wrap and the low-byte underflow one gate pulse at a time.

// File: rtl/tmr_pkg.sv
// Shared types for the timer channel.
// Assumes the configuration word is six bits wide, packed MSB first as below.
package tmr_pkg;

    typedef enum logic [1:0] {
        MD_ONESHOT = 2'b00,
        MD_CONT    = 2'b01,
        MD_WDOG    = 2'b10,
        MD_PWM     = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      edge_clk;   // count gate edges instead of prescaled clocks
        logic      pol;        // output polarity
        tmr_mode_e mode;       // operating mode
        logic [1:0] psel;      // divide select / gate enable
    } tmr_cfg_t;

endpackage

// File: rtl/tmr_prescale.sv
// Prescaler: a cycle counter that emits a one-cycle tick every DIV_* clocks.
// Assumes restart and a change of psel arrive together, so the counter never
// sits above the new limit. It holds its phase while enable is low.
module tmr_prescale #(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       enable,
    input  logic [1:0] psel,
    output logic       tick
);
    localparam int PRE_W = $clog2(DIV_SLOW);
    localparam logic [PRE_W-1:0] LIM_F = PRE_W'(DIV_FAST - 1);
    localparam logic [PRE_W-1:0] LIM_M = PRE_W'(DIV_MID - 1);
    localparam logic [PRE_W-1:0] LIM_S = PRE_W'(DIV_SLOW - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Pick the wrap limit from the divide select.
    always_comb begin
        if (psel[1])      lim = LIM_F;
        else if (psel[0]) lim = LIM_M;
        else              lim = LIM_S;
    end

    assign tick = enable && (pre_q == lim);

    // Advance, wrap or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (restart)  pre_q <= '0;
        else if (tick)     pre_q <= '0;
        else if (enable)   pre_q <= pre_q + 1'b1;
    end

    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= lim);

endmodule

// File: rtl/tmr_gate_sync.sv
// Gate input synchronizer with edge detection.
// Assumes gate_i is asynchronous. It needs STAGES >= 2 and reports
// level, rise and fall after the last stage.
module tmr_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // First stage samples the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= gate_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sh_q[STAGES-1];
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] && !prev_q;
    assign fall  = !sh_q[STAGES-1] && prev_q;

    assert_rise_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/tmr_strobe.sv
// Underflow strobe stretcher: holds strobe_o high for LEN clocks after a trig.
// A trig during an active strobe restarts the window.
module tmr_strobe #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic strobe_o
);
    localparam int SW = $clog2(LEN + 1);
    logic [SW-1:0] left_q;

    // Load the window on a trigger, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (trig)          left_q <= SW'(LEN);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign strobe_o = (left_q != '0);

    assert_strobe_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> strobe_o);

endmodule

// File: rtl/tmr_channel.sv
// Multi-mode timer channel top: one-shot, continuous, watchdog and split-byte
// PWM. It counts prescaled clocks, gate-enabled clocks, or gate edges.
// Assumes cfg_we and load_we are single-cycle strobes. cfg_we wins over
// load_we, and a start wins over a same-cycle count tick.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int STROBE_LEN  = 4,
    parameter int DIV_FAST    = 4,
    parameter int DIV_MID     = 16,
    parameter int DIV_SLOW    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_word,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             gate_in,
    output logic             pulse_out,
    output logic             strobe_out,
    output logic [CNT_W-1:0] count_out,
    output logic             running
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    tmr_cfg_t         cfg_q, cfg_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
    logic             flag_q, flag_d, run_q, run_d;
    logic [1:0]       md;
    logic             edge_mode, gate_mode, pwm_mode, wdog_mode;
    logic             gate_lvl, gate_rise, gate_fall, edge_hit;
    logic             pre_tick, pre_en, pre_restart;
    logic             start_ok, start_now, tick, low_zero, uflow;

    assign md        = cfg_q.mode;
    assign edge_mode = cfg_q.edge_clk;
    assign gate_mode = !cfg_q.edge_clk && (cfg_q.psel == 2'b11);
    assign pwm_mode  = (md == MD_PWM);
    assign wdog_mode = (md == MD_WDOG);

    // A non-watchdog load starts the count unless PWM is already running.
    assign start_ok  = !pwm_mode || !run_q;
    assign start_now = load_we && !cfg_we && (wdog_mode || start_ok);
    assign pre_restart = cfg_we || start_now;
    assign pre_en    = run_q && !edge_mode && (!gate_mode || gate_lvl);
    assign edge_hit  = cfg_q.psel[0] ? gate_fall : gate_rise;
    assign tick      = run_q && !cfg_we && !start_now &&
                       (edge_mode ? edge_hit : pre_tick);
    assign low_zero  = pwm_mode ? (cnt_q[HALF-1:0] == '0) : (cnt_q == '0);
    assign uflow     = tick && low_zero;

    tmr_prescale #(
        .DIV_FAST (DIV_FAST),
        .DIV_MID  (DIV_MID),
        .DIV_SLOW (DIV_SLOW)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (pre_restart),
        .enable  (pre_en),
        .psel    (cfg_q.psel),
        .tick    (pre_tick)
    );

    tmr_gate_sync #(
        .STAGES (SYNC_STAGES)
    ) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_in),
        .level  (gate_lvl),
        .rise   (gate_rise),
        .fall   (gate_fall)
    );

    tmr_strobe #(
        .LEN (STROBE_LEN)
    ) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (uflow),
        .strobe_o (strobe_out)
    );

    // Next-state logic for configuration, count, reload value and flags.
    always_comb begin
        cfg_d  = cfg_q;
        cnt_d  = cnt_q;
        rld_d  = rld_q;
        flag_d = flag_q;
        run_d  = run_q;
        if (cfg_we) begin
            cfg_d = tmr_cfg_t'(cfg_word);
            run_d = 1'b0;
        end else begin
            if (tick) begin
                if (low_zero) begin
                    flag_d = !flag_q;
                    if (md[0]) begin
                        cnt_d = rld_q;
                    end else begin
                        cnt_d = ALL_ONES;
                        run_d = 1'b0;
                    end
                end else if (pwm_mode) begin
                    cnt_d = {cnt_q[CNT_W-1:HALF] - 1'b1, cnt_q[HALF-1:0] - 1'b1};
                    if (cnt_q[CNT_W-1:HALF] == '0) flag_d = 1'b0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            if (load_we) begin
                if (wdog_mode) begin
                    cnt_d = rld_q;
                    run_d = 1'b1;
                end else begin
                    rld_d = load_val;
                    if (start_ok) begin
                        cnt_d  = load_val;
                        run_d  = 1'b1;
                        flag_d = 1'b1;
                    end
                end
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= ALL_ONES;
            rld_q  <= ALL_ONES;
            flag_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            cfg_q  <= cfg_d;
            cnt_q  <= cnt_d;
            rld_q  <= rld_d;
            flag_q <= flag_d;
            run_q  <= run_d;
        end
    end

    assign pulse_out = flag_q ^ cfg_q.pol;
    assign count_out = cnt_q;
    assign running   = run_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (count_out == ALL_ONES && !running && !pulse_out && !strobe_out));

    assert_park_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !md[0]) |=> (count_out == ALL_ONES && !running));

    assert_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pulse_out == ($past(pulse_out) ^ $past(cfg_word[4]) ^ $past(cfg_q.pol))));

    assert_strobe_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_out) |-> $past(strobe_out, 4));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && md[0]) |=> (running && count_out == $past(rld_q)));

    assert_pwm_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && !cfg_we && pwm_mode && run_q) |=> running);

    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && gate_mode && !gate_lvl && !cfg_we && !load_we) |=> $stable(count_out));

    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!running && $stable(count_out)));

endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, load_we, gate_in;
    logic [5:0]  cfg_word;
    logic [15:0] load_val;
    logic        pulse_out, strobe_out, running;
    logic [15:0] count_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_word   (cfg_word),
        .load_we    (load_we),
        .load_val   (load_val),
        .gate_in    (gate_in),
        .pulse_out  (pulse_out),
        .strobe_out (strobe_out),
        .count_out  (count_out),
        .running    (running)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // All drive tasks enter and leave at a falling edge.
    task automatic do_cfg(input logic [5:0] w);
        cfg_word = w; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_load(input logic [15:0] v);
        load_val = v; load_we = 1'b1;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic wait_strobe(output int k);
        k = 0;
        while (!strobe_out && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_pulse(output int k);
        logic p;
        p = pulse_out;
        k = 0;
        while (pulse_out == p && k < 5000) begin @(negedge clk); k++; end
    endtask

    task automatic gate_pulse();
        gate_in = 1'b1; idle(4);
        gate_in = 1'b0; idle(4);
    endtask

    function automatic int div_of(input int s);
        return (s >= 2) ? 4 : (s == 1) ? 16 : 256;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int k, m, c;
        rst_n = 1'b0; cfg_we = 1'b0; load_we = 1'b0; gate_in = 1'b0;
        cfg_word = '0; load_val = '0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", count_out, 16'hFFFF);
        chk("R1 running", running, 0);
        chk("R1 pulse", pulse_out, 0);
        chk("R1 strobe", strobe_out, 0);

        // R2 / R3 / R4: one-shot sweep over divide and start value
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n < ((s == 0) ? 2 : 8); n++) begin
                do_cfg(6'(s));
                idle(2);
                do_load(16'(n));
                chk("R3 start pulse", pulse_out, 1);
                wait_strobe(k);
                chk("R2 period", k, div_of(s) * (n + 1));
                chk("R2 park", count_out, 16'hFFFF);
                chk("R2 stop", running, 0);
                chk("R4 flag flip", pulse_out, 0);
                m = 0;
                while (strobe_out && m < 100) begin @(negedge clk); m++; end
                chk("R4 strobe len", m, 4);
            end
        end

        // R3 polarity change is immediate
        do_cfg(6'h12);
        chk("R3 polarity", pulse_out, 1);
        do_load(16'd3);
        chk("R3 active low", pulse_out, 0);
        wait_strobe(k);
        chk("R3 period", k, 16);
        chk("R3 end level", pulse_out, 1);
        idle(8);

        // R5 continuous reload
        for (int n = 1; n < 6; n++) begin
            do_cfg(6'h06);
            idle(8);
            do_load(16'(n));
            wait_strobe(k);
            chk("R5 first period", k, 4 * (n + 1));
            chk("R5 reload", count_out, n);
            wait_pulse(k);
            chk("R5 second period", k, 4 * (n + 1));
            chk("R5 running", running, 1);
        end
        // R12: configuration write stops and holds
        idle(3);
        c = count_out;
        do_cfg(6'h06);
        chk("R12 hold", count_out, c);
        chk("R12 stop", running, 0);
        idle(20);
        chk("R12 hold later", count_out, c);

        // R6 watchdog
        do_cfg(6'h02);
        do_load(16'd5);
        do_cfg(6'h0A);
        idle(8);
        do_load(16'hBEEF);
        chk("R6 data ignored", count_out, 5);
        wait_strobe(k);
        chk("R6 expiry", k, 24);
        chk("R6 park", count_out, 16'hFFFF);
        chk("R6 stop", running, 0);
        chk("R6 toggle", pulse_out, 0);
        idle(8);
        do_load(16'h1234);
        idle(15);
        do_load(16'h4321);
        chk("R6 retrigger", count_out, 5);
        wait_strobe(k);
        chk("R6 retrigger expiry", k, 24);
        chk("R6 toggle back", pulse_out, 1);
        idle(8);

        // R7 prescaled PWM sweep
        for (int hi = 0; hi < 4; hi++) begin
            for (int lo = hi + 1; lo < 6; lo++) begin
                do_cfg(6'h0E);
                idle(6);
                do_load({8'(hi), 8'(lo)});
                chk("R7 start", pulse_out, 1);
                wait_pulse(k);
                chk("R7 duty", k, 4 * (hi + 1));
                wait_pulse(k);
                chk("R7 rest", k, 4 * (lo - hi));
                chk("R7 reload", count_out, hi * 256 + lo);
                wait_pulse(k);
                chk("R7 duty again", k, 4 * (hi + 1));
            end
        end

        // R8 PWM write while running
        do_cfg(6'h0E);
        idle(6);
        do_load(16'h0103);
        wait_pulse(k);
        wait_pulse(k);
        do_load(16'h0005);
        chk("R8 count kept", count_out, 16'h0103);
        chk("R8 running", running, 1);
        wait_pulse(k);
        chk("R8 old duty", k, 7);
        wait_pulse(k);
        chk("R8 old rest", k, 8);
        chk("R8 new reload", count_out, 16'h0005);
        wait_pulse(k);
        chk("R8 new duty", k, 4);
        wait_pulse(k);
        chk("R8 new rest", k, 20);

        // R9 gate as count enable
        do_cfg(6'h03);
        idle(8);
        do_load(16'd9);
        idle(20);
        chk("R9 held low", count_out, 9);
        chk("R9 running", running, 1);
        gate_in = 1'b1; idle(12);
        gate_in = 1'b0; idle(6);
        chk("R9 partial", count_out, 6);
        idle(20);
        chk("R9 paused", count_out, 6);
        gate_in = 1'b1;
        wait_strobe(k);
        chk("R9 resume", k, 30);
        gate_in = 1'b0;
        idle(8);

        // R10 rising-edge counting
        do_cfg(6'h20);
        idle(6);
        do_load(16'd4);
        for (int e = 1; e <= 4; e++) begin
            gate_pulse();
            chk("R10 edge count", count_out, 4 - e);
        end
        gate_pulse();
        chk("R10 underflow park", count_out, 16'hFFFF);
        chk("R10 stop", running, 0);
        chk("R10 flag", pulse_out, 0);
        // R10 falling-edge select
        do_cfg(6'h21);
        idle(8);
        do_load(16'd3);
        gate_in = 1'b1; idle(6);
        chk("R10 rise ignored", count_out, 3);
        gate_in = 1'b0; idle(6);
        chk("R10 fall counted", count_out, 2);

        // R11 edge-clocked PWM
        do_cfg(6'h2C);
        idle(6);
        do_load(16'h0103);
        gate_pulse();
        chk("R11 both dec", count_out, 16'h0002);
        chk("R11 still active", pulse_out, 1);
        gate_pulse();
        chk("R11 high wrap", count_out, 16'hFF01);
        chk("R11 flag cleared", pulse_out, 0);
        gate_pulse();
        chk("R11 dec", count_out, 16'hFE00);
        gate_pulse();
        chk("R11 reload", count_out, 16'h0103);
        chk("R11 flag set", pulse_out, 1);
        chk("R11 running", running, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule